// File: doc/BRIEF.md
# Reconfigurable Shift-Add 1-D Transform Core

This block computes a one-dimensional transform over a vector of eight signed samples, using only shifts and additions. A two-bit mode input picks one of three transforms: an eight-point DCT, the eight-point integer transform used by the high-profile video codec, or the four-point integer core transform of the same codec. In the four-point mode the eight lanes carry two independent four-sample vectors. All three modes share one butterfly stage and one constant-coefficient stage. In DCT mode each cosine factor is a fixed constant with seven fractional bits, realised as a sum of shifted copies. In the integer modes the constants are exact, so the result is exact.

A vector is presented with `in_valid`. Its coefficients appear on `out_data` with `out_valid` exactly three clock cycles later. The pipeline accepts a new vector on every cycle and has no backpressure. Each vector carries its own mode through the pipeline, so modes may change from one cycle to the next. Post-scaling, quantization and the 2-D transposition are handled outside this block.

Top module: `tx1d_core`

## Requirements
- R1: Input lane k occupies `in_data[k*9 +: 9]` (signed) and output lane k occupies `out_data[k*16 +: 16]` (signed). Mode 2'b00 selects the 8-point DCT, 2'b01 the 8-point integer transform, and 2'b10 or 2'b11 the 4-point integer transform. The mode is sampled together with each vector.
- R2: In mode 01, output lane k equals Σ T[k][n]·x[n] exactly. T is the integer matrix with these rows: row 0 all 8. Row 4 is 8,-8,-8,8,8,-8,-8,8. Row 2 is 8,4,-4,-8,-8,-4,4,8. Row 6 is 4,-8,8,-4,-4,8,-8,4. Row 1 is 12,10,6,3,-3,-6,-10,-12. Row 3 is 10,-3,-12,-6,6,12,3,-10. Row 5 is 6,-12,3,10,-10,-3,12,-6. Row 7 is 3,-6,10,-12,12,-10,6,-3.
- R3: In mode 1x, lanes 0..3 transform x0..x3 and lanes 4..7 transform x4..x7, independently. For a group a,b,c,d the four outputs are a+b+c+d, then 2(a−d)+(b−c), then a−b−c+d, then (a−d)−2(b−c). All are exact.
- R4: In mode 00, output lane 0 approximates Σx[n]. Output lane k≥1 approximates √2·Σx[n]·cos((2n+1)kπ/16). Both equal 2√2 times the orthonormal-style DCT value F(k). Each output is within ±10 of the exact value.
- R5: `out_valid` is high in a cycle exactly when `in_valid` was high three cycles earlier, in every mode and for back-to-back vectors.
- R6: While `out_valid` is low, `out_data` keeps its previous value. Data presented with `in_valid` low has no effect on any later output.
- R7: During synchronous active-low reset, `out_valid` and `out_data` are zero.
- R8: Full-scale 9-bit inputs, all +255, all −256 or alternating, never overflow the 16-bit outputs in either integer mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input vector strobe |
| in_mode | input | 2 | Transform select for this vector |
| in_data | input | 72 | Eight signed 9-bit samples, lane 0 in the low bits |
| out_valid | output | 1 | Output vector strobe |
| out_data | output | 128 | Eight signed 16-bit coefficients, lane 0 in the low bits |

## Verification
Some properties are checked by assertions on every cycle. These are the three-cycle valid latency, the hold of the output register while no result is emitted, and the lane pairing chosen by the butterfly for each transform length. Assertions also check that no integer-mode result carries a fraction and that no integer-mode result exceeds the output range. The numerical correctness of each mode can only be shown by the bench's scenarios. Those scenarios include exact matching against the integer matrices, the bounded DCT error, the independence of the two four-point groups, and mode changes between adjacent vectors.

// File: rtl/tx_pkg.sv
// Package tx_pkg: shared widths, mode codes, coefficient constants and the
// shift-add constant multiplier used by the transform datapath.
// Assumes constants fit in 16 bits; all arithmetic is two's complement.
package tx_pkg;
    localparam int LANES    = 8;
    localparam int HALF     = LANES / 2;
    localparam int ACC_W    = 32;
    localparam int FRAC     = 7;
    localparam int K_UNIT   = 1 << FRAC;
    localparam int HALF_LSB = 1 << (FRAC - 1);

    typedef enum logic [1:0] {
        MODE_DCT8 = 2'd0,
        MODE_INT8 = 2'd1,
        MODE_INT4 = 2'd2,
        MODE_INT4B = 2'd3
    } tx_mode_e;

    typedef logic signed [ACC_W-1:0] acc_t;

    // Odd-row constants c1,c3,c5,c7 in Q7: sqrt(2)*cos(k*pi/16)
    localparam int KO_DCT [HALF] = '{178, 151, 101, 35};
    // Odd-row constants 12,10,6,3 scaled to Q7
    localparam int KO_INT [HALF] = '{1536, 1280, 768, 384};
    // Even constants: DC gain, cos(pi/8) term, cos(3pi/8) term, in Q7
    localparam int KE_DCT [3] = '{128, 167, 69};
    localparam int KE_INT [3] = '{1024, 1024, 512};

    // Multiply by a constant with shifts and adds only; k is an elaboration constant
    function automatic acc_t cmul(input acc_t x, input int k);
        acc_t        r;
        int unsigned m;
        r = '0;
        m = (k < 0) ? int'(-k) : k;
        for (int b = 0; b < 16; b++) begin
            if (m[b]) r = r + (x <<< b);
        end
        return (k < 0) ? -r : r;
    endfunction

    // Four-term constant dot product used by the odd rows
    function automatic acc_t dot4(input acc_t q0, input acc_t q1, input acc_t q2,
                                  input acc_t q3, input int k0, input int k1,
                                  input int k2, input int k3);
        return cmul(q0, k0) + cmul(q1, k1) + cmul(q2, k2) + cmul(q3, k3);
    endfunction
endpackage

// File: rtl/tx_butterfly.sv
// Module tx_butterfly: first pipeline stage. Forms sums and differences of
// lane pairs. For 8-point modes lane j pairs with lane 7-j; for 4-point modes
// the pairs are (0,3),(1,2),(4,7),(5,6). Registers results and the mode.
// Assumes in_data lanes are signed W_IN-bit values.
module tx_butterfly
    import tx_pkg::*;
#(
    parameter int W_IN = 9
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [1:0]                in_mode,
    input  logic [LANES*W_IN-1:0]     in_data,
    output logic                      bf_valid,
    output logic [1:0]                bf_mode,
    output logic [HALF*(W_IN+1)-1:0]  bf_sum,
    output logic [HALF*(W_IN+1)-1:0]  bf_dif
);
    localparam int P_W = W_IN + 1;

    logic signed [W_IN-1:0] lane [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane[g] = in_data[g*W_IN +: W_IN];
    end

    // Purpose: carry valid and mode alongside the data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bf_valid <= 1'b0;
            bf_mode  <= MODE_DCT8;
        end else begin
            bf_valid <= in_valid;
            if (in_valid) bf_mode <= in_mode;
        end
    end

    for (genvar j = 0; j < HALF; j++) begin : g_pair
        localparam int LO8 = j;
        localparam int HI8 = LANES - 1 - j;
        localparam int LO4 = (j < 2) ? j : j + 2;
        localparam int HI4 = (j < 2) ? 3 - j : 9 - j;

        logic signed [W_IN-1:0] x_lo, x_hi;
        logic signed [P_W-1:0]  s_q, d_q;

        // Purpose: pick the partner lanes for this butterfly by transform length
        always_comb begin
            if (in_mode[1]) begin
                x_lo = lane[LO4];
                x_hi = lane[HI4];
            end else begin
                x_lo = lane[LO8];
                x_hi = lane[HI8];
            end
        end

        // Purpose: register the pair sum and difference on a valid input
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                s_q <= '0;
                d_q <= '0;
            end else if (in_valid) begin
                s_q <= P_W'(x_lo) + P_W'(x_hi);
                d_q <= P_W'(x_lo) - P_W'(x_hi);
            end
        end

        assign bf_sum[j*P_W +: P_W] = s_q;
        assign bf_dif[j*P_W +: P_W] = d_q;

        // R1: pairing follows the registered mode's transform length
        p_pair_lo_r1: assert property (@(posedge clk) disable iff (!rst_n)
            bf_valid |-> (int'(s_q) + int'(d_q) ==
                2 * (bf_mode[1] ? int'($past(lane[LO4])) : int'($past(lane[LO8])))))
            else $error("pair low lane mismatch");
        p_pair_hi_r1: assert property (@(posedge clk) disable iff (!rst_n)
            bf_valid |-> (int'(s_q) - int'(d_q) ==
                2 * (bf_mode[1] ? int'($past(lane[HI4])) : int'($past(lane[HI8])))))
            else $error("pair high lane mismatch");
    end
endmodule

// File: rtl/tx_kernel.sv
// Module tx_kernel: second pipeline stage. Applies the even and odd constant
// networks for the selected mode to the butterfly outputs and registers
// eight Q7 accumulators. All constant products are shift-add trees.
// Assumes bf_sum/bf_dif lanes are signed P_W-bit values.
module tx_kernel
    import tx_pkg::*;
#(
    parameter int P_W = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bf_valid,
    input  logic [1:0]              bf_mode,
    input  logic [HALF*P_W-1:0]     bf_sum,
    input  logic [HALF*P_W-1:0]     bf_dif,
    output logic                    kn_valid,
    output logic [1:0]              kn_mode,
    output logic [LANES*ACC_W-1:0]  kn_acc
);
    acc_t sv [HALF];
    acc_t dv [HALF];
    acc_t e0, e1, e2, e3;
    acc_t r_dct [LANES];
    acc_t r_i8  [LANES];
    acc_t r_i4  [LANES];
    acc_t r_sel [LANES];
    acc_t acc_q [LANES];

    for (genvar g = 0; g < HALF; g++) begin : g_unpack
        assign sv[g] = ACC_W'($signed(bf_sum[g*P_W +: P_W]));
        assign dv[g] = ACC_W'($signed(bf_dif[g*P_W +: P_W]));
    end

    // Purpose: evaluate all three constant networks and select by mode
    always_comb begin
        e0 = sv[0] + sv[3];
        e1 = sv[1] + sv[2];
        e2 = sv[0] - sv[3];
        e3 = sv[1] - sv[2];

        r_dct[0] = cmul(e0 + e1, KE_DCT[0]);
        r_dct[4] = cmul(e0 - e1, KE_DCT[0]);
        r_dct[2] = cmul(e2, KE_DCT[1]) + cmul(e3, KE_DCT[2]);
        r_dct[6] = cmul(e2, KE_DCT[2]) - cmul(e3, KE_DCT[1]);
        r_dct[1] = dot4(dv[0], dv[1], dv[2], dv[3],  KO_DCT[0],  KO_DCT[1],  KO_DCT[2],  KO_DCT[3]);
        r_dct[3] = dot4(dv[0], dv[1], dv[2], dv[3],  KO_DCT[1], -KO_DCT[3], -KO_DCT[0], -KO_DCT[2]);
        r_dct[5] = dot4(dv[0], dv[1], dv[2], dv[3],  KO_DCT[2], -KO_DCT[0],  KO_DCT[3],  KO_DCT[1]);
        r_dct[7] = dot4(dv[0], dv[1], dv[2], dv[3],  KO_DCT[3], -KO_DCT[2],  KO_DCT[1], -KO_DCT[0]);

        r_i8[0] = cmul(e0 + e1, KE_INT[0]);
        r_i8[4] = cmul(e0 - e1, KE_INT[0]);
        r_i8[2] = cmul(e2, KE_INT[1]) + cmul(e3, KE_INT[2]);
        r_i8[6] = cmul(e2, KE_INT[2]) - cmul(e3, KE_INT[1]);
        r_i8[1] = dot4(dv[0], dv[1], dv[2], dv[3],  KO_INT[0],  KO_INT[1],  KO_INT[2],  KO_INT[3]);
        r_i8[3] = dot4(dv[0], dv[1], dv[2], dv[3],  KO_INT[1], -KO_INT[3], -KO_INT[0], -KO_INT[2]);
        r_i8[5] = dot4(dv[0], dv[1], dv[2], dv[3],  KO_INT[2], -KO_INT[0],  KO_INT[3],  KO_INT[1]);
        r_i8[7] = dot4(dv[0], dv[1], dv[2], dv[3],  KO_INT[3], -KO_INT[2],  KO_INT[1], -KO_INT[0]);

        for (int h = 0; h < 2; h++) begin
            r_i4[4*h+0] = cmul(sv[2*h] + sv[2*h+1], K_UNIT);
            r_i4[4*h+1] = cmul((dv[2*h] <<< 1) + dv[2*h+1], K_UNIT);
            r_i4[4*h+2] = cmul(sv[2*h] - sv[2*h+1], K_UNIT);
            r_i4[4*h+3] = cmul(dv[2*h] - (dv[2*h+1] <<< 1), K_UNIT);
        end

        for (int k = 0; k < LANES; k++) begin
            case (bf_mode)
                MODE_DCT8: r_sel[k] = r_dct[k];
                MODE_INT8: r_sel[k] = r_i8[k];
                default:   r_sel[k] = r_i4[k];
            endcase
        end
    end

    // Purpose: carry valid and mode to the rounding stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kn_valid <= 1'b0;
            kn_mode  <= MODE_DCT8;
        end else begin
            kn_valid <= bf_valid;
            if (bf_valid) kn_mode <= bf_mode;
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_acc
        // Purpose: register the selected accumulator of this lane
        always_ff @(posedge clk) begin
            if (!rst_n)        acc_q[g] <= '0;
            else if (bf_valid) acc_q[g] <= r_sel[g];
        end

        assign kn_acc[g*ACC_W +: ACC_W] = acc_q[g];

        // R2, R3: integer modes leave no fractional bits in the accumulator
        p_int_exact_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (kn_valid && kn_mode != MODE_DCT8) |-> (acc_q[g][FRAC-1:0] == '0))
            else $error("integer mode accumulator has fraction");
    end
endmodule

// File: rtl/tx_round.sv
// Module tx_round: third pipeline stage. Rounds each Q7 accumulator to the
// nearest integer (half rounds up) and registers the W_OUT-bit result.
// Holds the output register when no result is valid.
module tx_round
    import tx_pkg::*;
#(
    parameter int W_OUT = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    kn_valid,
    input  logic [1:0]              kn_mode,
    input  logic [LANES*ACC_W-1:0]  kn_acc,
    output logic                    out_valid,
    output logic [LANES*W_OUT-1:0]  out_data
);
    acc_t rnd [LANES];

    // Purpose: output strobe register
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= kn_valid;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_rnd
        logic [W_OUT-1:0] o_q;

        assign rnd[g] = ($signed(kn_acc[g*ACC_W +: ACC_W]) + ACC_W'(HALF_LSB)) >>> FRAC;

        // Purpose: register the rounded coefficient on a valid accumulator
        always_ff @(posedge clk) begin
            if (!rst_n)        o_q <= '0;
            else if (kn_valid) o_q <= rnd[g][W_OUT-1:0];
        end

        assign out_data[g*W_OUT +: W_OUT] = o_q;

        // R8: integer-mode results fit the output width
        p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (kn_valid && kn_mode != MODE_DCT8) |->
                (rnd[g] >= -(acc_t'(1) <<< (W_OUT-1)) && rnd[g] < (acc_t'(1) <<< (W_OUT-1))))
            else $error("integer result exceeds output width");
    end

    // R6: output register holds while no result is emitted
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_data))
        else $error("output changed without a valid result");
endmodule

// File: rtl/tx1d_core.sv
// Module tx1d_core: top of the reconfigurable shift-add 1-D transform.
// Three-stage pipeline: butterfly, constant network, rounding. Fixed latency
// of three cycles in every mode, one vector per cycle, no backpressure.
module tx1d_core
    import tx_pkg::*;
#(
    parameter int W_IN  = 9,
    parameter int W_OUT = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [1:0]              in_mode,
    input  logic [LANES*W_IN-1:0]   in_data,
    output logic                    out_valid,
    output logic [LANES*W_OUT-1:0]  out_data
);
    localparam int P_W = W_IN + 1;

    logic                    bf_valid, kn_valid;
    logic [1:0]              bf_mode, kn_mode;
    logic [HALF*P_W-1:0]     bf_sum, bf_dif;
    logic [LANES*ACC_W-1:0]  kn_acc;

    tx_butterfly #(.W_IN(W_IN)) u_bfly (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_mode(in_mode), .in_data(in_data),
        .bf_valid(bf_valid), .bf_mode(bf_mode), .bf_sum(bf_sum), .bf_dif(bf_dif)
    );

    tx_kernel #(.P_W(P_W)) u_kern (
        .clk(clk), .rst_n(rst_n),
        .bf_valid(bf_valid), .bf_mode(bf_mode), .bf_sum(bf_sum), .bf_dif(bf_dif),
        .kn_valid(kn_valid), .kn_mode(kn_mode), .kn_acc(kn_acc)
    );

    tx_round #(.W_OUT(W_OUT)) u_rnd (
        .clk(clk), .rst_n(rst_n),
        .kn_valid(kn_valid), .kn_mode(kn_mode), .kn_acc(kn_acc),
        .out_valid(out_valid), .out_data(out_data)
    );

    // R5: output strobe follows the input strobe by exactly three cycles
    p_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid, 3))
        else $error("valid latency mismatch");
endmodule

// File: tb/tx1d_core_test.sv
module tx1d_core_test;
    localparam int W_IN  = 9;
    localparam int W_OUT = 16;
    localparam int NL    = 8;

    // Integer 8-point matrix, row-major
    localparam int M8 [64] = '{
         8,  8,  8,  8,  8,  8,  8,  8,
        12, 10,  6,  3, -3, -6,-10,-12,
         8,  4, -4, -8, -8, -4,  4,  8,
        10, -3,-12, -6,  6, 12,  3,-10,
         8, -8, -8,  8,  8, -8, -8,  8,
         6,-12,  3, 10,-10, -3, 12, -6,
         4, -8,  8, -4, -4,  8, -8,  4,
         3, -6, 10,-12, 12,-10,  6, -3};

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  in_valid = 1'b0;
    logic [1:0]            in_mode = 2'd0;
    logic [NL*W_IN-1:0]    in_data = '0;
    logic                  out_valid;
    logic [NL*W_OUT-1:0]   out_data;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    logic               h_valid [4];
    logic [1:0]         h_mode  [4];
    logic [NL*W_IN-1:0] h_data  [4];
    string              h_tag   [4];
    logic [NL*W_OUT-1:0] last_out = '0;

    tx1d_core #(.W_IN(W_IN), .W_OUT(W_OUT)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mode(in_mode),
        .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
    );

    always #5 clk = ~clk;

    function automatic int xin(logic [NL*W_IN-1:0] d, int n);
        return int'($signed(d[n*W_IN +: W_IN]));
    endfunction

    function automatic int yout(int k);
        return int'($signed(out_data[k*W_OUT +: W_OUT]));
    endfunction

    function automatic int ref_int(logic [1:0] m, logic [NL*W_IN-1:0] d, int k);
        int acc = 0;
        int b, a0, a1, a2, a3;
        if (m == 2'd1) begin
            for (int n = 0; n < NL; n++) acc += M8[k*NL+n] * xin(d, n);
            return acc;
        end
        b  = (k / 4) * 4;
        a0 = xin(d, b); a1 = xin(d, b+1); a2 = xin(d, b+2); a3 = xin(d, b+3);
        case (k % 4)
            0:       return a0 + a1 + a2 + a3;
            1:       return 2*(a0 - a3) + (a1 - a2);
            2:       return a0 - a1 - a2 + a3;
            default: return (a0 - a3) - 2*(a1 - a2);
        endcase
    endfunction

    function automatic real ref_dct(logic [NL*W_IN-1:0] d, int k);
        real acc = 0.0;
        for (int n = 0; n < NL; n++)
            acc += $itor(xin(d, n)) * $cos((2.0*n + 1.0) * k * 3.14159265358979 / 16.0);
        return (k == 0) ? acc : acc * $sqrt(2.0);
    endfunction

    task automatic fail(string tag, string what, real act, real exp);
        fails++;
        $display("FAIL %s %s actual=%0.3f expected=%0.3f (cycle %0d)", tag, what, act, exp, cyc);
    endtask

    task automatic compare_vec(logic [1:0] m, logic [NL*W_IN-1:0] d, string tag);
        for (int k = 0; k < NL; k++) begin
            checks++;
            if (m == 2'd0) begin
                real e = ref_dct(d, k);
                real diff = $itor(yout(k)) - e;
                if (diff > 10.0 || diff < -10.0) fail(tag, $sformatf("dct lane %0d", k), $itor(yout(k)), e);
            end else begin
                int e = ref_int(m, d, k);
                if (yout(k) != e) fail(tag, $sformatf("int lane %0d", k), $itor(yout(k)), $itor(e));
            end
        end
    endtask

    // One cycle: check the outputs due now, then drive the next input
    task automatic step(bit v, logic [1:0] m, logic [NL*W_IN-1:0] d, string tag);
        int idx;
        @(negedge clk);
        idx = (cyc + 1) % 4;
        checks++;
        if (out_valid !== h_valid[idx]) fail("R5", "out_valid", $itor(out_valid), $itor(h_valid[idx]));
        if (out_valid && h_valid[idx]) compare_vec(h_mode[idx], h_data[idx], h_tag[idx]);
        else if (!out_valid) begin
            checks++;
            if (out_data !== last_out) fail("R6", "held out_data changed", 1.0, 0.0);
        end
        last_out = out_data;
        in_valid = v;
        in_mode  = m;
        in_data  = d;
        h_valid[cyc % 4] = v;
        h_mode[cyc % 4]  = m;
        h_data[cyc % 4]  = d;
        h_tag[cyc % 4]   = tag;
        cyc++;
    endtask

    function automatic string mode_tag(logic [1:0] m);
        case (m)
            2'd0:    return "R4";
            2'd1:    return "R2";
            2'd2:    return "R3";
            default: return "R1";
        endcase
    endfunction

    function automatic int pat(int p, int k);
        case (p)
            0:       return 255;
            1:       return -256;
            2:       return (k % 2 == 0) ? 255 : -256;
            3:       return (k == 3) ? 200 : 0;
            4:       return k * 37 - 130;
            default: return (k < 4) ? -256 : 255;
        endcase
    endfunction

    function automatic logic [NL*W_IN-1:0] pack_pat(int p);
        logic [NL*W_IN-1:0] d;
        for (int k = 0; k < NL; k++) d[k*W_IN +: W_IN] = W_IN'(pat(p, k));
        return d;
    endfunction

    function automatic logic [NL*W_IN-1:0] rnd_vec();
        logic [NL*W_IN-1:0] d;
        for (int k = 0; k < NL; k++) d[k*W_IN +: W_IN] = W_IN'(int'($urandom_range(511, 0)) - 256);
        return d;
    endfunction

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL R5 watchdog expired actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        int seed;
        seed = int'($urandom(32'd2024));
        for (int i = 0; i < 4; i++) begin
            h_valid[i] = 1'b0; h_mode[i] = 2'd0; h_data[i] = '0; h_tag[i] = "";
        end
        // R7: reset state
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0) fail("R7", "out_valid in reset", $itor(out_valid), 0.0);
        checks++;
        if (out_data !== '0) fail("R7", "out_data in reset", 1.0, 0.0);
        rst_n = 1'b1;

        // Directed patterns in every mode, back to back; full scale tagged R8
        for (int p = 0; p < 6; p++)
            for (int m = 0; m < 4; m++)
                step(1'b1, 2'(m), pack_pat(p),
                     (p < 3 && m != 0) ? "R8" : mode_tag(2'(m)));

        // R6: idle cycles with garbage data, then a known vector
        for (int i = 0; i < 6; i++) step(1'b0, 2'(i % 4), rnd_vec(), "R6");
        step(1'b1, 2'd1, pack_pat(4), "R6");
        for (int i = 0; i < 4; i++) step(1'b0, 2'd0, rnd_vec(), "R6");

        // R1: impulse in each lane separates the two 4-point groups
        for (int n = 0; n < NL; n++) begin
            logic [NL*W_IN-1:0] d = '0;
            d[n*W_IN +: W_IN] = W_IN'(100 + n);
            step(1'b1, 2'd2, d, "R1");
        end

        // Random traffic with random mode changes and gaps
        for (int i = 0; i < 3000; i++) begin
            logic [1:0] m = 2'($urandom_range(3, 0));
            bit v = ($urandom_range(3, 0) != 0);
            step(v, m, rnd_vec(), v ? mode_tag(m) : "R6");
        end

        // Flush the pipeline
        for (int i = 0; i < 5; i++) step(1'b0, 2'd0, '0, "R5");

        done = 1'b1;
        summary();
        $finish;
    end
endmodule